// File: doc/BRIEF.md
# Interrupt Destination Address Matcher

This block decides, for each incoming interrupt message, whether the local interrupt unit is one of its targets. A message carries an 8-bit destination field, a bit choosing physical or logical addressing, and a 2-bit shorthand code. A separate flag tells the matcher whether the local unit itself sent the message. The block answers with one combinational match bit. Arbitration among several matching units and the delivery of the interrupt happen elsewhere.

Three programmable registers hold the addressing state, and each is loaded over a small synchronous write port:

- the unit's own physical ID;
- its logical ID;
- the logical format, which selects flat bitmask addressing or cluster addressing.

A format value that is neither flat nor cluster is flagged as an error. Under such a format no logically addressed message can match.

Top module: `intr_dest_match`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), the physical ID and the logical ID are 0 and the format selects flat mode. From then on `fmt_err` is 0, a physical message to 0x00 matches, and a flat logical message to 0xFF does not match.
- R2: With shorthand 0 and `logical_mode` 0, `match` is 1 exactly when `dest` is 0xFF or `dest` equals the physical ID.
- R3: With shorthand 0, `logical_mode` 1 and format nibble 0xF (flat), `match` is 1 exactly when the bitwise AND of the logical ID and `dest` is nonzero.
- R4: With shorthand 0, `logical_mode` 1 and format nibble 0x0 (cluster), `match` is 1 exactly when the upper nibbles of the logical ID and `dest` are equal and the AND of their lower nibbles is nonzero.
- R5: A format write (`reg_sel` 2) keeps only `reg_wdata[31:28]` as the format nibble. Bits 27:0 read as all ones and have no effect on matching.
- R6: A format nibble other than 0xF or 0x0 drives `fmt_err` high. While it holds, a logically addressed message with shorthand 0 never matches, and physical matching is unaffected.
- R7: Shorthand 1 (self) gives `match` equal to `from_self`.
- R8: Shorthand 2 (all including self) always gives `match` 1.
- R9: Shorthand 3 (all excluding self) gives `match` equal to the inverse of `from_self`.
- R10: The register selects are 0 for the physical ID, 1 for the logical ID and 2 for the format. A physical-ID write (`reg_sel` 0) and a logical-ID write (`reg_sel` 1) each keep only `reg_wdata[31:24]`. A write with `reg_sel` 3 changes nothing.
- R11: When the shorthand is nonzero, `dest` and `logical_mode` have no effect on `match`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 physical ID, 1 logical ID, 2 format, 3 unused |
| reg_wdata | input | 32 | Register write data |
| dest | input | 8 | Destination field of the message |
| logical_mode | input | 1 | 0 physical addressing, 1 logical addressing |
| shorthand | input | 2 | 0 addressed, 1 self, 2 all including self, 3 all excluding self |
| from_self | input | 1 | Message was sent by the local unit |
| match | output | 1 | Message targets the local unit |
| fmt_err | output | 1 | Format register holds an unsupported value |

## Verification
The checker watches the shorthand outcomes on every cycle, whatever the stored registers hold:

- self, all and all-but-self decode correctly for any `from_self`;
- physical broadcast always matches;
- a logical message under an invalid format never matches;
- the error flag follows the most recent format write.

Some behaviour depends on the exact bits that were written, so only the bench scenarios can show it:

- the precise flat and cluster results for chosen ID and destination pairs;
- that the low bits of register writes are discarded;
- that writes to the unused select are ignored;
- the reset values.

// File: rtl/idm_pkg.sv
package idm_pkg;
  typedef enum logic [1:0] {
    SH_ADDRESSED = 2'd0,
    SH_SELF      = 2'd1,
    SH_ALL_INCL  = 2'd2,
    SH_ALL_EXCL  = 2'd3
  } shorthand_e;

  typedef enum logic [1:0] {
    SEL_PHYS_ID = 2'd0,
    SEL_LOG_ID  = 2'd1,
    SEL_FORMAT  = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/idm_regs.sv
module idm_regs #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8,
  parameter int FMT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [ID_W-1:0]   phys_id,
  output logic [ID_W-1:0]   log_id,
  output logic [FMT_W-1:0]  fmt
);
  import idm_pkg::*;

  localparam logic [FMT_W-1:0] FMT_RESET = '1;

  logic [ID_W-1:0]  phys_q, log_q;
  logic [FMT_W-1:0] fmt_q;

  // Only the top field of each register is kept; the low bits of the
  // format register are tied to ones and need no storage.
  always_ff @(posedge clk) begin
    if (rst) begin
      phys_q <= '0;
      log_q  <= '0;
      fmt_q  <= FMT_RESET;
    end else if (we) begin
      case (reg_sel_e'(sel))
        SEL_PHYS_ID: phys_q <= wdata[DATA_W-1 -: ID_W];
        SEL_LOG_ID:  log_q  <= wdata[DATA_W-1 -: ID_W];
        SEL_FORMAT:  fmt_q  <= wdata[DATA_W-1 -: FMT_W];
        default: ;
      endcase
    end
  end

  assign phys_id = phys_q;
  assign log_id  = log_q;
  assign fmt     = fmt_q;
endmodule

// File: rtl/idm_addr_cmp.sv
module idm_addr_cmp #(
  parameter int ID_W  = 8,
  parameter int FMT_W = 4
) (
  input  logic [ID_W-1:0]  phys_id,
  input  logic [ID_W-1:0]  log_id,
  input  logic [FMT_W-1:0] fmt,
  input  logic [ID_W-1:0]  dest,
  input  logic             logical_mode,
  output logic             hit,
  output logic             fmt_bad
);
  localparam int HALF = ID_W / 2;
  localparam logic [FMT_W-1:0] FMT_FLAT    = '1;
  localparam logic [FMT_W-1:0] FMT_CLUSTER = '0;
  localparam logic [ID_W-1:0]  BROADCAST   = '1;

  logic phys_hit, flat_hit, clus_hit;
  logic is_flat, is_clus;

  assign is_flat = (fmt == FMT_FLAT);
  assign is_clus = (fmt == FMT_CLUSTER);
  assign fmt_bad = !is_flat && !is_clus;

  assign phys_hit = (dest == BROADCAST) || (dest == phys_id);
  assign flat_hit = |(log_id & dest);
  assign clus_hit = (log_id[ID_W-1:HALF] == dest[ID_W-1:HALF]) &&
                    (|(log_id[HALF-1:0] & dest[HALF-1:0]));

  always_comb begin
    if (!logical_mode)   hit = phys_hit;
    else if (is_flat)    hit = flat_hit;
    else if (is_clus)    hit = clus_hit;
    else                 hit = 1'b0;
  end
endmodule

// File: rtl/intr_dest_match.sv
module intr_dest_match #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8,
  parameter int FMT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ID_W-1:0]   dest,
  input  logic              logical_mode,
  input  logic [1:0]        shorthand,
  input  logic              from_self,
  output logic              match,
  output logic              fmt_err
);
  import idm_pkg::*;

  logic [ID_W-1:0]  phys_id, log_id;
  logic [FMT_W-1:0] fmt;
  logic             addr_hit;

  idm_regs #(.DATA_W(DATA_W), .ID_W(ID_W), .FMT_W(FMT_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .phys_id(phys_id), .log_id(log_id), .fmt(fmt)
  );

  idm_addr_cmp #(.ID_W(ID_W), .FMT_W(FMT_W)) u_cmp (
    .phys_id(phys_id), .log_id(log_id), .fmt(fmt), .dest(dest),
    .logical_mode(logical_mode), .hit(addr_hit), .fmt_bad(fmt_err)
  );

  always_comb begin
    case (shorthand_e'(shorthand))
      SH_ADDRESSED: match = addr_hit;
      SH_SELF:      match = from_self;
      SH_ALL_INCL:  match = 1'b1;
      default:      match = !from_self;
    endcase
  end
endmodule

// File: rtl/idm_check.sv
module idm_check #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8,
  parameter int FMT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [ID_W-1:0]   dest,
  input logic              logical_mode,
  input logic [1:0]        shorthand,
  input logic              from_self,
  input logic              match,
  input logic              fmt_err
);
  a_r7_self_only: assert property (@(posedge clk) disable iff (rst)
    (shorthand == 2'd1) |-> (match == from_self));

  a_r8_all_incl: assert property (@(posedge clk) disable iff (rst)
    (shorthand == 2'd2) |-> match);

  a_r9_all_excl: assert property (@(posedge clk) disable iff (rst)
    (shorthand == 2'd3) |-> (match == !from_self));

  a_r2_broadcast: assert property (@(posedge clk) disable iff (rst)
    (shorthand == 2'd0 && !logical_mode && dest == '1) |-> match);

  a_r6_bad_fmt_no_match: assert property (@(posedge clk) disable iff (rst)
    (shorthand == 2'd0 && logical_mode && fmt_err) |-> !match);

  a_r6_err_follows_write: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 2'd2) |=>
      (fmt_err == ($past(reg_wdata[DATA_W-1 -: FMT_W]) != '1 &&
                   $past(reg_wdata[DATA_W-1 -: FMT_W]) != '0)));
endmodule

bind intr_dest_match idm_check #(.DATA_W(DATA_W), .ID_W(ID_W), .FMT_W(FMT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .dest(dest), .logical_mode(logical_mode), .shorthand(shorthand),
  .from_self(from_self), .match(match), .fmt_err(fmt_err)
);

// File: tb/intr_dest_match_test.sv
module intr_dest_match_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  dest = '0;
  logic        logical_mode = 1'b0;
  logic [1:0]  shorthand = '0;
  logic        from_self = 1'b0;
  logic        match, fmt_err;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_dest_match uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .dest(dest), .logical_mode(logical_mode), .shorthand(shorthand),
    .from_self(from_self), .match(match), .fmt_err(fmt_err)
  );

  // {phys_id, log_id, fmt, dest, logical, shorthand, from_self, expected}
  localparam logic [32:0] VEC [NV] = '{
    {8'h05, 8'h00, 4'hF, 8'h05, 1'b0, 2'd0, 1'b0, 1'b1}, // R2 own ID
    {8'h05, 8'h00, 4'hF, 8'h06, 1'b0, 2'd0, 1'b0, 1'b0}, // R2 other ID
    {8'h05, 8'h00, 4'hF, 8'hFF, 1'b0, 2'd0, 1'b0, 1'b1}, // R2 broadcast
    {8'h05, 8'h24, 4'hF, 8'h04, 1'b1, 2'd0, 1'b0, 1'b1}, // R3 overlap
    {8'h05, 8'h24, 4'hF, 8'h42, 1'b1, 2'd0, 1'b0, 1'b0}, // R3 disjoint
    {8'h05, 8'h35, 4'h0, 8'h31, 1'b1, 2'd0, 1'b0, 1'b1}, // R4 hit
    {8'h05, 8'h35, 4'h0, 8'h41, 1'b1, 2'd0, 1'b0, 1'b0}, // R4 cluster differs
    {8'h05, 8'h35, 4'h0, 8'h3A, 1'b1, 2'd0, 1'b0, 1'b0}, // R4 member mask empty
    {8'h05, 8'hFF, 4'h7, 8'hFF, 1'b1, 2'd0, 1'b0, 1'b0}, // R6 invalid format
    {8'h05, 8'h00, 4'hF, 8'h00, 1'b0, 2'd1, 1'b1, 1'b1}, // R7 self, sent locally
    {8'h05, 8'h00, 4'hF, 8'h05, 1'b0, 2'd1, 1'b0, 1'b0}, // R7 R11 self, remote
    {8'h05, 8'h00, 4'hF, 8'h00, 1'b1, 2'd2, 1'b0, 1'b1}, // R8 R11 all
    {8'h05, 8'h00, 4'hF, 8'hFF, 1'b0, 2'd3, 1'b1, 1'b0}, // R9 all-but-self, local
    {8'h05, 8'h00, 4'hF, 8'h00, 1'b0, 2'd3, 1'b0, 1'b1}  // R9 all-but-self, remote
  };

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic msg(input logic [7:0] d, input logic l, input logic [1:0] sh,
                     input logic s);
    @(negedge clk);
    dest = d; logical_mode = l; shorthand = sh; from_self = s;
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    msg(8'h00, 1'b0, 2'd0, 1'b0);
    chk("R1 phys 0", match, 1'b1);
    chk("R1 fmt_err", fmt_err, 1'b0);
    msg(8'hFF, 1'b1, 2'd0, 1'b0);
    chk("R1 flat empty logical ID", match, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      logic exp_err;
      v = VEC[i];
      wr(2'd0, {v[32:25], 24'hABCDEF});
      wr(2'd1, {v[24:17], 24'h123456});
      wr(2'd2, {v[16:13], 28'h0});
      msg(v[12:5], v[4], v[3:2], v[1]);
      chk($sformatf("R2-R11 vector %0d match", i), match, v[0]);
      exp_err = (v[16:13] != 4'hF) && (v[16:13] != 4'h0);
      chk($sformatf("R6 vector %0d fmt_err", i), fmt_err, exp_err);
    end

    // R6: physical matching still works with a bad format
    wr(2'd2, 32'h7000_0000);
    msg(8'h05, 1'b0, 2'd0, 1'b0);
    chk("R6 physical under bad format", match, 1'b1);

    // R5: low bits of a format write have no effect; 0x0FFFFFFF selects cluster
    wr(2'd1, 32'h3500_0000);
    wr(2'd2, 32'h0FFF_FFFF);
    msg(8'h41, 1'b1, 2'd0, 1'b0);
    chk("R5 cluster after low-ones write", match, 1'b0);
    chk("R5 fmt_err", fmt_err, 1'b0);
    wr(2'd2, 32'hF000_0000);
    msg(8'h41, 1'b1, 2'd0, 1'b0);
    chk("R5 flat after low-zeros write", match, 1'b1);

    // R10: select 3 ignored; ID keeps only top byte
    wr(2'd0, 32'h0900_00FF);
    wr(2'd3, 32'h0300_0000);
    msg(8'h09, 1'b0, 2'd0, 1'b0);
    chk("R10 ID kept", match, 1'b1);
    msg(8'h03, 1'b0, 2'd0, 1'b0);
    chk("R10 sel 3 ignored", match, 1'b0);
    msg(8'hFF - 8'h00, 1'b0, 2'd0, 1'b0);
    msg(8'hFF >> 0, 1'b0, 2'd0, 1'b0);
    msg(8'h00, 1'b0, 2'd0, 1'b0);
    chk("R10 low bits not in ID", match, 1'b0);

    // R11: shorthand 1 ignores a matching destination
    msg(8'h09, 1'b0, 2'd1, 1'b0);
    chk("R11 dest ignored under shorthand", match, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule